// File: doc/BRIEF.md
# Flash Block Erase Unlock Controller

This block sits between a CPU register bus and an on-chip flash array and guards the self-erase path. Software loads a 22-bit table pointer and then writes two key bytes to a dedicated key register. It then writes the control register with the enable, erase-select and start bits set. Only this exact sequence, with no other bus access in between, launches an erase of one fixed 1024-byte block. The block is the one the upper pointer bits select.

While the erase runs, the block raises a CPU stall output for a long-write period set by an internal cycle timer. At the end it releases the stall, clears its busy state and pulses a done flag. The unlock state is cleared after every erase, so each new erase needs a fresh key sequence. Interrupt masking around the sequence is left to software.

Top module: `flash_erase_guard`

## Requirements
- R1: After reset, busy, cpu_stall, erase_req and done are 0, and every register reads as 0.
- R2: The pointer is written and read as three bytes: address 2 holds bits 7:0, address 3 holds bits 15:8, and address 4 holds bits 21:16 in its low six bits (the upper two bits read 0).
- R3: Three writes launch an erase: 0x55 to the key register (address 1), then 0xAA to the key register, then a control write (address 0) with bit 1 (start), bit 2 (write enable) and bit 4 (erase select) all 1. On the clock edge that takes the control write, busy rises and erase_req pulses for exactly one cycle. In that cycle erase_blk carries pointer bits 21:10.
- R4: Pointer bits 9:0 have no effect on erase_blk; each erase covers a whole 1024-byte block.
- R5: A wrong key value, the keys in the wrong order, or any other bus read or write between the steps returns the unlock tracker to idle, and a following control write with start does not erase.
- R6: A control write with start set but no completed unlock does nothing, and control bit 1 reads back as 0.
- R7: After a completed unlock, a control write with start set but write enable 0 or erase select 0 does not erase.
- R8: busy and cpu_stall stay 1 for exactly TIMER_CYCLES clock cycles per erase, and control bit 1 reads as 1 during that time.
- R9: When the timer expires, busy and control bit 1 clear without any CPU action, and done is 1 for exactly one cycle.
- R10: A completed erase leaves the unlock tracker idle, so a control write with start alone does not launch another erase.
- R11: Bus writes during an erase are ignored: the pointer and key tracking are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe, one access per cycle |
| bus_rd | input | 1 | Register read strobe, one access per cycle |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| erase_req | output | 1 | One-cycle block-erase request to the flash array |
| erase_blk | output | 12 | Block number to erase, held while busy |
| cpu_stall | output | 1 | Stalls the CPU during the long write |
| busy | output | 1 | Erase in progress |
| done | output | 1 | One-cycle pulse when the erase finishes |

## Verification
The assertions assume that bus_wr and bus_rd are never high together, and that no access arrives while cpu_stall is high except where the bench deliberately probes the ignored-write rule. They also assume that reset is held for at least one edge. The bench issues every access as a single-cycle strobe launched on the falling edge, with only one strobe high at a time. It runs erases only through the key sequence, so the checker's rule that busy can rise only after a qualifying control write reflects legal traffic. Its timer-window count uses the bench's short TIMER_CYCLES.

// File: rtl/flash_erase_guard.sv
module flash_erase_guard #(
  parameter int TIMER_CYCLES = 20000,
  parameter int PTR_W        = 22,
  parameter int BLK_BYTES    = 1024,
  parameter logic [7:0] KEY_A = 8'h55,
  parameter logic [7:0] KEY_B = 8'hAA
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                bus_wr,
  input  logic                                bus_rd,
  input  logic [2:0]                          bus_addr,
  input  logic [7:0]                          bus_wdata,
  output logic [7:0]                          bus_rdata,
  output logic                                erase_req,
  output logic [PTR_W-$clog2(BLK_BYTES)-1:0]  erase_blk,
  output logic                                cpu_stall,
  output logic                                busy,
  output logic                                done
);
  localparam int OFS_W = $clog2(BLK_BYTES);
  localparam int UP_W  = PTR_W - 16;
  localparam int CNT_W = $clog2(TIMER_CYCLES + 1);
  localparam logic [2:0] A_CTRL = 3'd0, A_KEY = 3'd1, A_PLO = 3'd2,
                         A_PMID = 3'd3, A_PUP = 3'd4;
  localparam int B_START = 1, B_WEN = 2, B_ERS = 4;

  typedef enum logic [1:0] {U_IDLE, U_HALF, U_ARMED} ustate_t;

  ustate_t          ust, ust_nxt;
  logic [PTR_W-1:0] ptr;
  logic             wen, ers;
  logic [CNT_W-1:0] cnt;

  wire acc     = (bus_wr | bus_rd) & ~busy;
  wire wr_ok   = bus_wr & ~busy;
  wire key_wr  = wr_ok & (bus_addr == A_KEY);
  wire ctl_wr  = wr_ok & (bus_addr == A_CTRL);
  wire expire  = busy & (cnt == '0);
  wire start   = ctl_wr & (ust == U_ARMED) & bus_wdata[B_START]
                 & bus_wdata[B_WEN] & bus_wdata[B_ERS];

  always_comb begin
    ust_nxt = ust;
    if (busy) ust_nxt = U_IDLE;
    else if (acc) begin
      case (ust)
        U_IDLE:  ust_nxt = (key_wr && bus_wdata == KEY_A) ? U_HALF  : U_IDLE;
        U_HALF:  ust_nxt = (key_wr && bus_wdata == KEY_B) ? U_ARMED : U_IDLE;
        default: ust_nxt = U_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ust <= U_IDLE;
    else        ust <= ust_nxt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr <= '0;
      wen <= 1'b0;
      ers <= 1'b0;
    end else if (wr_ok) begin
      case (bus_addr)
        A_CTRL: begin wen <= bus_wdata[B_WEN]; ers <= bus_wdata[B_ERS]; end
        A_PLO:  ptr[7:0]       <= bus_wdata;
        A_PMID: ptr[15:8]      <= bus_wdata;
        A_PUP:  ptr[PTR_W-1:16] <= bus_wdata[UP_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      done      <= 1'b0;
      erase_req <= 1'b0;
      erase_blk <= '0;
      cnt       <= '0;
    end else begin
      erase_req <= start;
      done      <= expire;
      if (start) begin
        busy      <= 1'b1;
        cnt       <= CNT_W'(TIMER_CYCLES - 1);
        erase_blk <= ptr[PTR_W-1:OFS_W];
      end else if (expire) begin
        busy <= 1'b0;
      end else if (busy) begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  assign cpu_stall = busy;

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (bus_addr)
        A_CTRL: begin
          bus_rdata[B_START] = busy;
          bus_rdata[B_WEN]   = wen;
          bus_rdata[B_ERS]   = ers;
        end
        A_PLO:  bus_rdata = ptr[7:0];
        A_PMID: bus_rdata = ptr[15:8];
        A_PUP:  bus_rdata[UP_W-1:0] = ptr[PTR_W-1:16];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/flash_erase_guard_chk.sv
module flash_erase_guard_chk #(
  parameter int TIMER_CYCLES = 20000,
  parameter int BLK_W        = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_wr,
  input logic [2:0]       bus_addr,
  input logic [7:0]       bus_wdata,
  input logic             erase_req,
  input logic [BLK_W-1:0] erase_blk,
  input logic             cpu_stall,
  input logic             busy,
  input logic             done
);
  int run_len;

  always_ff @(posedge clk) begin
    if (!rst_n)    run_len <= 0;
    else if (busy) run_len <= run_len + 1;
    else           run_len <= 0;
  end

  assert_stall_tracks_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_stall == busy);

  assert_req_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    erase_req |=> !erase_req);

  assert_req_at_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    erase_req |-> busy && !$past(busy));

  assert_start_needs_ctl_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(bus_wr && bus_addr == 3'd0 && bus_wdata[1]
                          && bus_wdata[2] && bus_wdata[4]));

  assert_done_after_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && $past(busy));

  assert_fall_gives_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_window_length_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> run_len == TIMER_CYCLES);

  assert_no_overrun_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> run_len < TIMER_CYCLES);

  assert_blk_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(erase_blk));
endmodule

bind flash_erase_guard flash_erase_guard_chk #(
  .TIMER_CYCLES(TIMER_CYCLES),
  .BLK_W(PTR_W - $clog2(BLK_BYTES))
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .erase_req(erase_req), .erase_blk(erase_blk),
  .cpu_stall(cpu_stall), .busy(busy), .done(done)
);

// File: tb/flash_erase_guard_test.sv
module flash_erase_guard_test;
  localparam int T = 12;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       erase_req, cpu_stall, busy, done;
  logic [11:0] erase_blk;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  flash_erase_guard #(.TIMER_CYCLES(T)) uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .erase_req(erase_req), .erase_blk(erase_blk), .cpu_stall(cpu_stall),
    .busy(busy), .done(done)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic set_ptr(input logic [21:0] p);
    wr(3'd2, p[7:0]);
    wr(3'd3, p[15:8]);
    wr(3'd4, {2'b00, p[21:16]});
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic expect_no_erase(input string req);
    logic [7:0] v;
    check({req, " busy"}, busy, 0);
    check({req, " erase_req"}, erase_req, 0);
    rd(3'd0, v);
    check({req, " start bit"}, v[1], 0);
  endtask

  task automatic t_reset_R1();
    logic [7:0] v;
    check("R1 busy", busy, 0);
    check("R1 stall", cpu_stall, 0);
    check("R1 done", done, 0);
    check("R1 erase_req", erase_req, 0);
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), v);
      check("R1 reg", v, 0);
    end
  endtask

  task automatic t_ptr_R2();
    logic [7:0] v;
    wr(3'd2, 8'h5A); wr(3'd3, 8'hC3); wr(3'd4, 8'hFF);
    rd(3'd2, v); check("R2 low", v, 8'h5A);
    rd(3'd3, v); check("R2 mid", v, 8'hC3);
    rd(3'd4, v); check("R2 up", v, 8'h3F);
  endtask

  task automatic t_erase_R3_R8_R9(input logic [21:0] p, input logic [11:0] exp_blk, input string tag);
    int n = 0;
    set_ptr(p);
    wr(3'd1, 8'h55); wr(3'd1, 8'hAA); wr(3'd0, 8'h16);
    check({tag, " R3 erase_req"}, erase_req, 1);
    check({tag, " R3 blk"}, erase_blk, exp_blk);
    while (busy) begin
      n++;
      if (n == 2) check({tag, " R3 req one cycle"}, erase_req, 0);
      check({tag, " R8 stall"}, cpu_stall, 1);
      check({tag, " R9 no early done"}, done, 0);
      @(negedge clk);
    end
    check({tag, " R8 length"}, n, T);
    check({tag, " R9 done"}, done, 1);
    @(negedge clk);
    check({tag, " R9 done single"}, done, 0);
  endtask

  task automatic t_offset_R4();
    t_erase_R3_R8_R9(22'h2A_BFFF, 12'hAAF, "R4 ones");
    t_erase_R3_R8_R9(22'h2A_BC00, 12'hAAF, "R4 zeros");
  endtask

  task automatic t_abort_R5();
    logic [7:0] v;
    wr(3'd1, 8'h55); wr(3'd1, 8'hAB); wr(3'd0, 8'h16);
    expect_no_erase("R5 wrong key");
    wr(3'd1, 8'hAA); wr(3'd1, 8'h55); wr(3'd0, 8'h16);
    expect_no_erase("R5 order");
    wr(3'd1, 8'h55); rd(3'd2, v); wr(3'd1, 8'hAA); wr(3'd0, 8'h16);
    expect_no_erase("R5 read between");
    wr(3'd1, 8'h55); wr(3'd1, 8'hAA); wr(3'd2, 8'h00); wr(3'd0, 8'h16);
    expect_no_erase("R5 write before start");
  endtask

  task automatic t_no_unlock_R6();
    wr(3'd0, 8'h16);
    expect_no_erase("R6");
  endtask

  task automatic t_bits_R7();
    logic [7:0] v;
    wr(3'd1, 8'h55); wr(3'd1, 8'hAA); wr(3'd0, 8'h12);
    expect_no_erase("R7 wen0");
    wr(3'd1, 8'h55); wr(3'd1, 8'hAA); wr(3'd0, 8'h06);
    expect_no_erase("R7 ers0");
    rd(3'd0, v);
    check("R7 ctrl readback", v, 8'h04);
  endtask

  task automatic t_busy_R8_R11();
    logic [7:0] v;
    set_ptr(22'h01_0400);
    wr(3'd1, 8'h55); wr(3'd1, 8'hAA); wr(3'd0, 8'h16);
    rd(3'd0, v);
    check("R8 start bit while busy", v[1], 1);
    wr(3'd2, 8'hEE);
    wr(3'd1, 8'h55);
    wait_idle();
    rd(3'd0, v);
    check("R9 start bit cleared", v[1], 0);
    rd(3'd2, v);
    check("R11 ptr unchanged", v, 8'h00);
    wr(3'd1, 8'hAA); wr(3'd0, 8'h16);
    expect_no_erase("R11 key ignored");
  endtask

  task automatic t_fresh_R10();
    t_erase_R3_R8_R9(22'h00_0800, 12'h002, "R10 first");
    wr(3'd0, 8'h16);
    expect_no_erase("R10 restart");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_R1();
    t_ptr_R2();
    t_erase_R3_R8_R9(22'h3F_FC00, 12'hFFF, "R3 top");
    t_offset_R4();
    t_abort_R5();
    t_no_unlock_R6();
    t_bits_R7();
    t_busy_R8_R11();
    t_fresh_R10();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule